// File: doc/BRIEF.md
# Coprocessor Control Register Interface

This block is the register file that a scalar processor reaches with its move-to-coprocessor and move-from-coprocessor instructions. A 4-bit index picks one of the words: four DMA setup words (local address, main-memory address, read length, write length), a control/status word, a DMA-busy flag, a hardware semaphore, and the command-buffer start, end and status words of a downstream display processor. The processor sees a read port (enable, index, 32-bit data) and a write port (enable, index, 32-bit data), which may both be active in the same cycle.

Two accesses have side effects. Reading the semaphore word is an atomic test-and-set: the reader gets the old bit and the bit becomes 1, so of several contenders exactly one sees 0. Writing the command end word aligns the value to an 8-byte boundary within a 24-bit address range and fires a one-cycle run pulse toward the display processor. A write to the display status word is not stored here; it is passed on with a one-cycle strobe. Any access to an index that has no meaning for that direction sets a sticky error flag.

Top module: `cop_ctrl_regs`

## Requirements
- R1: While rst_n is low at a rising clock edge, every register (the four DMA words, ctrl_status, cmd_start, cmd_cur, cmd_end, stat_wr_data), the semaphore, rd_data, run_cmd, stat_wr and access_err become zero.
- R2: A write to index 0, 1, 2 or 3 loads wr_data into dma_lcl_addr, dma_main_addr, dma_rd_len or dma_wr_len respectively; a write to index 4 loads ctrl_status, and a read of index 4 returns ctrl_status as it was before any write in the same cycle.
- R3: A read of index 5 returns the dma_full input in bit 0 with bits 31:1 zero; a read of index 6 returns zero.
- R4: A read of index 7 returns the semaphore in bit 0 (bits 31:1 zero) and sets the semaphore to 1, so after a release the first read returns 0 and later reads return 1.
- R5: A write to index 7 clears the semaphore only when wr_data is zero; a nonzero write leaves it unchanged. When a read and a zero write of index 7 arrive in the same cycle, the read returns the old bit and the semaphore becomes 0.
- R6: A write to index 8 loads both cmd_start and cmd_cur with wr_data AND 0x00FFFFF8.
- R7: A write to index 9 loads cmd_end with wr_data AND 0x00FFFFF8, and run_cmd is high for exactly the cycle after that write edge; otherwise run_cmd is low.
- R8: A read of index 11 returns the dp_status input; a write to index 11 makes stat_wr high for the cycle after the write edge with stat_wr_data equal to the written word, and stat_wr is low otherwise.
- R9: A read of an index other than 4, 5, 6, 7, 11, or a write to an index other than 0, 1, 2, 3, 4, 7, 8, 9, 11, sets access_err, which stays set until reset; such a read returns zero and such a write changes no register.
- R10: rd_data is registered: it shows the value selected by a read on the edge that samples rd_en and keeps that value while rd_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| dma_full | input | 1 | DMA-busy flag from the DMA engine |
| dp_status | input | 32 | Display processor status word |
| dma_lcl_addr | output | 32 | DMA local-memory address |
| dma_main_addr | output | 32 | DMA main-memory address |
| dma_rd_len | output | 32 | DMA read length |
| dma_wr_len | output | 32 | DMA write length |
| ctrl_status | output | 32 | Control/status word |
| cmd_start | output | 32 | Aligned command start pointer |
| cmd_cur | output | 32 | Command current pointer |
| cmd_end | output | 32 | Aligned command end pointer |
| run_cmd | output | 1 | One-cycle command run pulse |
| stat_wr | output | 1 | One-cycle status write strobe |
| stat_wr_data | output | 32 | Data forwarded with stat_wr |
| access_err | output | 1 | Sticky illegal-access flag |

## Verification
Every result of this block is due one edge after the access: the register words, the semaphore, rd_data, the two pulses and the error flag all change on the edge that samples the strobes. The bench drives an access, waits for that single rising edge, steps 1 ns past it and compares every output with a model that was advanced using the state from before the edge, so a read that meets a write of the same word in one cycle is expected to return the old value. The semaphore's ignored nonzero write and the no-effect illegal write are judged through later reads and the register outputs, and the pulses are checked low on every cycle with no triggering write.

// File: rtl/ccr_pkg.sv
// Package ccr_pkg
// Shared index codes and legality decoders for the coprocessor control
// register interface. Assumes a 4-bit index space.
package ccr_pkg;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IX_DMA_LCL  = 4'd0;
    localparam logic [IDX_W-1:0] IX_DMA_MAIN = 4'd1;
    localparam logic [IDX_W-1:0] IX_DMA_RLEN = 4'd2;
    localparam logic [IDX_W-1:0] IX_DMA_WLEN = 4'd3;
    localparam logic [IDX_W-1:0] IX_STATUS   = 4'd4;
    localparam logic [IDX_W-1:0] IX_DMA_FULL = 4'd5;
    localparam logic [IDX_W-1:0] IX_ZERO     = 4'd6;
    localparam logic [IDX_W-1:0] IX_SEM      = 4'd7;
    localparam logic [IDX_W-1:0] IX_CMD_BEG  = 4'd8;
    localparam logic [IDX_W-1:0] IX_CMD_END  = 4'd9;
    localparam logic [IDX_W-1:0] IX_DP_STAT  = 4'd11;

    // Number of plain storage words written by index 0..4
    localparam int N_PLAIN = 5;

    function automatic logic rd_legal(input logic [IDX_W-1:0] ix);
        return (ix == IX_STATUS) || (ix == IX_DMA_FULL) || (ix == IX_ZERO) ||
               (ix == IX_SEM) || (ix == IX_DP_STAT);
    endfunction

    function automatic logic wr_legal(input logic [IDX_W-1:0] ix);
        return (ix <= IX_STATUS) || (ix == IX_SEM) || (ix == IX_CMD_BEG) ||
               (ix == IX_CMD_END) || (ix == IX_DP_STAT);
    endfunction
endpackage

// File: rtl/ccr_plain_regs.sv
// Module ccr_plain_regs
// Holds the plain storage words written by indices 0..N_PLAIN-1 (DMA
// setup words and the control/status word). Assumes the caller qualifies
// wr_en with a legal index; indices at or above N_PLAIN are ignored here.
module ccr_plain_regs #(
    parameter int DW      = 32,
    parameter int IW      = 4,
    parameter int N_WORDS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] words [N_WORDS]
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        // Load this word when its own index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                word_q <= wr_data;
        end
        assign words[g] = word_q;

        AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IW'(g))) |=> (word_q == $past(wr_data))); // R2
    end
endmodule

// File: rtl/ccr_semaphore.sv
// Module ccr_semaphore
// One-bit hardware semaphore. An acquire (read) sets it, a release
// (zero-valued write) clears it; release wins when both arrive together.
// Assumes the caller reports the pre-edge value to the reader.
module ccr_semaphore (
    input  logic clk,
    input  logic rst_n,
    input  logic acquire,
    input  logic release_req,
    output logic sem_q
);
    // Next semaphore state with release taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            sem_q <= 1'b0;
        else if (release_req)
            sem_q <= 1'b0;
        else if (acquire)
            sem_q <= 1'b1;
    end

    AST_SEM_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acquire && !release_req) |=> sem_q); // R4
    AST_SEM_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> !sem_q); // R5
    AST_SEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acquire && !release_req) |=> $stable(sem_q)); // R5
endmodule

// File: rtl/ccr_cmd_ptrs.sv
// Module ccr_cmd_ptrs
// Display-processor command pointers and the two outbound pulses.
// Start and end pointers are masked to the aligned address range; a start
// write also seeds the current pointer. Pulses last exactly one cycle.
// Assumes each strobe input is already index-decoded and exclusive.
module ccr_cmd_ptrs #(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] PTR_MASK = 32'h00FF_FFF8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_start,
    input  logic          set_end,
    input  logic          set_stat,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cmd_start,
    output logic [DW-1:0] cmd_cur,
    output logic [DW-1:0] cmd_end,
    output logic          run_cmd,
    output logic          stat_wr,
    output logic [DW-1:0] stat_wr_data
);
    logic [DW-1:0] aligned;
    assign aligned = wr_data & PTR_MASK;

    // Start pointer and current pointer load together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start <= '0;
            cmd_cur   <= '0;
        end else if (set_start) begin
            cmd_start <= aligned;
            cmd_cur   <= aligned;
        end
    end

    // End pointer load and run pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_end <= '0;
            run_cmd <= 1'b0;
        end else begin
            run_cmd <= set_end;
            if (set_end)
                cmd_end <= aligned;
        end
    end

    // Status forward strobe with held data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_wr      <= 1'b0;
            stat_wr_data <= '0;
        end else begin
            stat_wr <= set_stat;
            if (set_stat)
                stat_wr_data <= wr_data;
        end
    end

    AST_CUR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        set_start |=> (cmd_cur == cmd_start)); // R6
    AST_RUN_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        set_end |=> run_cmd); // R7
    AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !set_end |=> !run_cmd); // R7
    AST_STAT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        set_stat |=> (stat_wr && (stat_wr_data == $past(wr_data)))); // R8
endmodule

// File: rtl/cop_ctrl_regs.sv
// Module cop_ctrl_regs
// Coprocessor control register interface: decodes a read port and a write
// port over a 4-bit index, owns the registered read mux and the sticky
// access-error flag, and instantiates the storage, semaphore and command
// pointer blocks. Assumes both ports may be active in one cycle.
module cop_ctrl_regs
    import ccr_pkg::*;
#(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] PTR_MASK = 32'h00FF_FFF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             dma_full,
    input  logic [DW-1:0]    dp_status,
    output logic [DW-1:0]    dma_lcl_addr,
    output logic [DW-1:0]    dma_main_addr,
    output logic [DW-1:0]    dma_rd_len,
    output logic [DW-1:0]    dma_wr_len,
    output logic [DW-1:0]    ctrl_status,
    output logic [DW-1:0]    cmd_start,
    output logic [DW-1:0]    cmd_cur,
    output logic [DW-1:0]    cmd_end,
    output logic             run_cmd,
    output logic             stat_wr,
    output logic [DW-1:0]    stat_wr_data,
    output logic             access_err
);
    logic          wr_ok, rd_ok;
    logic          plain_we;
    logic [DW-1:0] words [N_PLAIN];
    logic          sem_q;
    logic [DW-1:0] rd_sel;

    assign wr_ok    = wr_en && wr_legal(wr_idx);
    assign rd_ok    = rd_en && rd_legal(rd_idx);
    assign plain_we = wr_ok && (wr_idx < IDX_W'(N_PLAIN));

    ccr_plain_regs #(.DW(DW), .IW(IDX_W), .N_WORDS(N_PLAIN)) u_plain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (plain_we),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .words   (words)
    );

    assign dma_lcl_addr  = words[IX_DMA_LCL];
    assign dma_main_addr = words[IX_DMA_MAIN];
    assign dma_rd_len    = words[IX_DMA_RLEN];
    assign dma_wr_len    = words[IX_DMA_WLEN];
    assign ctrl_status   = words[IX_STATUS];

    ccr_semaphore u_sem (
        .clk         (clk),
        .rst_n       (rst_n),
        .acquire     (rd_ok && (rd_idx == IX_SEM)),
        .release_req (wr_ok && (wr_idx == IX_SEM) && (wr_data == '0)),
        .sem_q       (sem_q)
    );

    ccr_cmd_ptrs #(.DW(DW), .PTR_MASK(PTR_MASK)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_start    (wr_ok && (wr_idx == IX_CMD_BEG)),
        .set_end      (wr_ok && (wr_idx == IX_CMD_END)),
        .set_stat     (wr_ok && (wr_idx == IX_DP_STAT)),
        .wr_data      (wr_data),
        .cmd_start    (cmd_start),
        .cmd_cur      (cmd_cur),
        .cmd_end      (cmd_end),
        .run_cmd      (run_cmd),
        .stat_wr      (stat_wr),
        .stat_wr_data (stat_wr_data)
    );

    // Select the read word from pre-edge state; illegal indices give zero
    always_comb begin
        rd_sel = '0;
        case (rd_idx)
            IX_STATUS:   rd_sel = ctrl_status;
            IX_DMA_FULL: rd_sel = {{(DW-1){1'b0}}, dma_full};
            IX_ZERO:     rd_sel = '0;
            IX_SEM:      rd_sel = {{(DW-1){1'b0}}, sem_q};
            IX_DP_STAT:  rd_sel = dp_status;
            default:     rd_sel = '0;
        endcase
    end

    // Register the read word on each read strobe and hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_sel;
    end

    // Sticky flag for any access to an index without meaning
    always_ff @(posedge clk) begin
        if (!rst_n)
            access_err <= 1'b0;
        else if ((rd_en && !rd_ok) || (wr_en && !wr_ok))
            access_err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> access_err); // R9
    AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_legal(rd_idx)) |=> (rd_data == '0 && access_err)); // R9
    AST_BAD_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_legal(wr_idx)) |=> ($stable(ctrl_status) && $stable(dma_lcl_addr) &&
        $stable(cmd_start) && $stable(cmd_end) && !run_cmd && !stat_wr)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
    AST_SEM_OLD_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IX_SEM) |=> (rd_data == {{(DW-1){1'b0}}, $past(sem_q)})); // R4
endmodule

// File: tb/cop_ctrl_regs_tb_top.sv
// Bench for cop_ctrl_regs: directed corner cases followed by seeded
// random traffic, every output compared with a bench-side model.
module cop_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, dma_full = 1'b0;
    logic [3:0]  rd_idx = '0, wr_idx = '0;
    logic [31:0] wr_data = '0, dp_status = '0;
    logic [31:0] rd_data, dma_lcl_addr, dma_main_addr, dma_rd_len, dma_wr_len;
    logic [31:0] ctrl_status, cmd_start, cmd_cur, cmd_end, stat_wr_data;
    logic        run_cmd, stat_wr, access_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic [31:0] m_dma [4];
    logic [31:0] m_status, m_start, m_cur, m_end, m_swd, m_rd;
    logic        m_sem, m_run, m_sw, m_err;

    localparam logic [31:0] MASK = 32'h00FF_FFF8;

    cop_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .dma_full(dma_full),
        .dp_status(dp_status), .dma_lcl_addr(dma_lcl_addr), .dma_main_addr(dma_main_addr),
        .dma_rd_len(dma_rd_len), .dma_wr_len(dma_wr_len), .ctrl_status(ctrl_status),
        .cmd_start(cmd_start), .cmd_cur(cmd_cur), .cmd_end(cmd_end), .run_cmd(run_cmd),
        .stat_wr(stat_wr), .stat_wr_data(stat_wr_data), .access_err(access_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit rd_ok(input logic [3:0] ix);
        return ix == 4 || ix == 5 || ix == 6 || ix == 7 || ix == 11;
    endfunction

    function automatic bit wr_ok(input logic [3:0] ix);
        return ix <= 4 || ix == 7 || ix == 8 || ix == 9 || ix == 11;
    endfunction

    function automatic string rd_tag(input logic [3:0] ix);
        case (ix)
            4'd4: return "R2 status read";
            4'd5, 4'd6: return "R3 flag/zero read";
            4'd7: return "R4 semaphore read";
            4'd11: return "R8 dp status read";
            default: return "R9 illegal read";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_dma[i] = '0;
        m_status = '0; m_start = '0; m_cur = '0; m_end = '0; m_swd = '0; m_rd = '0;
        m_sem = 1'b0; m_run = 1'b0; m_sw = 1'b0; m_err = 1'b0;
    endtask

    task automatic compare_all(input string rtag);
        chk({rtag, " R10 rd_data"}, rd_data, m_rd);
        chk("R2 dma_lcl_addr", dma_lcl_addr, m_dma[0]);
        chk("R2 dma_main_addr", dma_main_addr, m_dma[1]);
        chk("R2 dma_rd_len", dma_rd_len, m_dma[2]);
        chk("R2 dma_wr_len", dma_wr_len, m_dma[3]);
        chk("R2 ctrl_status", ctrl_status, m_status);
        chk("R6 cmd_start", cmd_start, m_start);
        chk("R6 cmd_cur", cmd_cur, m_cur);
        chk("R7 cmd_end", cmd_end, m_end);
        chk("R7 run_cmd", {31'b0, run_cmd}, {31'b0, m_run});
        chk("R8 stat_wr", {31'b0, stat_wr}, {31'b0, m_sw});
        chk("R8 stat_wr_data", stat_wr_data, m_swd);
        chk("R9 access_err", {31'b0, access_err}, {31'b0, m_err});
    endtask

    // One access cycle: drive, take one edge, advance model, compare
    task automatic acc(input bit re, input logic [3:0] ri, input bit we,
                       input logic [3:0] wi, input logic [31:0] wd);
        string tag;
        rd_en = re; rd_idx = ri; wr_en = we; wr_idx = wi; wr_data = wd;
        @(posedge clk);
        tag = re ? rd_tag(ri) : "R10 hold";
        if (re && we && ri == 7 && wi == 7) tag = "R5 same-cycle";
        m_run = 1'b0; m_sw = 1'b0;
        if (re) begin
            case (ri)
                4'd4: m_rd = m_status;
                4'd5: m_rd = {31'b0, dma_full};
                4'd7: m_rd = {31'b0, m_sem};
                4'd11: m_rd = dp_status;
                default: m_rd = '0;
            endcase
            if (!rd_ok(ri)) m_err = 1'b1;
        end
        if (we && wi == 7 && wd == 0) m_sem = 1'b0;
        else if (re && ri == 7) m_sem = 1'b1;
        if (we) begin
            case (wi)
                4'd0, 4'd1, 4'd2, 4'd3: m_dma[wi[1:0]] = wd;
                4'd4: m_status = wd;
                4'd8: begin m_start = wd & MASK; m_cur = wd & MASK; end
                4'd9: begin m_end = wd & MASK; m_run = 1'b1; end
                4'd11: begin m_sw = 1'b1; m_swd = wd; end
                default: ;
            endcase
            if (!wr_ok(wi)) m_err = 1'b1;
        end
        #1;
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        @(posedge clk); @(posedge clk);
        model_reset();
        #1;
        compare_all("R1 reset");
        rst_n = 1'b1;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        #1;
        do_reset();
        // R4/R5 directed semaphore sequence
        acc(1, 7, 0, 0, 0);                   // first reader sees 0
        acc(1, 7, 0, 0, 0);                   // later reader sees 1
        acc(0, 0, 1, 7, 32'h1);               // nonzero write ignored
        acc(1, 7, 0, 0, 0);                   // still 1
        acc(0, 0, 1, 7, 32'h0);               // release
        acc(1, 7, 0, 0, 0);                   // 0 again
        acc(1, 7, 1, 7, 32'h0);               // same cycle: old 1, ends 0
        acc(1, 7, 0, 0, 0);                   // R5 release won
        // R6/R7/R8 pointers and pulses
        acc(0, 0, 1, 8, 32'hFFFF_FFFF);
        acc(0, 0, 1, 9, 32'h1234_5677);
        acc(0, 0, 1, 9, 32'h0000_0010);       // back-to-back run pulses
        acc(0, 0, 0, 0, 0);                   // pulse drops
        dp_status = 32'hA5A5_0001;
        acc(1, 11, 1, 11, 32'hCAFE_F00D);
        // R2 status write and same-cycle read sees old value
        acc(0, 0, 1, 4, 32'h0000_00FF);
        acc(1, 4, 1, 4, 32'h1111_2222);
        dma_full = 1'b1;
        acc(1, 5, 1, 0, 32'hDEAD_BEEF);
        acc(1, 6, 1, 3, 32'h0000_1000);
        // R9 illegal accesses
        acc(1, 0, 0, 0, 0);
        do_reset();
        acc(0, 0, 1, 5, 32'h5555_5555);
        acc(0, 0, 1, 15, 32'h7777_7777);
        acc(1, 4, 0, 0, 0);
        do_reset();
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] ri, wi;
            logic [31:0] wd;
            ri = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'(($urandom % 2) ? 7 : 4 + $urandom % 3);
            if ($urandom % 3 == 0) wi = 4'($urandom % 16);
            else wi = 4'($urandom % 12);
            if (($urandom % 8) == 0 && (wi == 10 || wi == 5 || wi == 6)) wi = 4'd7;
            wd = ($urandom % 3 == 0) ? 32'h0 : $urandom;
            dma_full = 1'($urandom % 2);
            dp_status = $urandom;
            if (n == 1500) do_reset();
            acc(1'($urandom % 2), ri, 1'($urandom % 2), wi, wd);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule